// File: doc/BRIEF.md
# Burst Address Counter

This block produces the address that one port of a dual-ported memory presents to its array. On every rising clock edge it chooses one of four actions: clear to zero, take in an externally supplied address, step forward by one, or keep its present value. A host starts a burst by strobing in a start address. It then holds the count-enable control active to walk through consecutive words. It drops the count enable whenever it needs the same word again.

All three controls are active low and are sampled only at the clock edge. When more than one is active, clear wins over load, and load wins over increment. The block has no chip-enable input, so the counter keeps acting on its controls while the port is deselected. Stepping forward from the all-ones address gives zero. The address width is a parameter and defaults to 14 bits, which covers a 16K-word array.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `mem_addr` is 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high and `clr_n` low at a rising edge, `mem_addr` becomes 0, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R3: With `clr_n` high and `strobe_n` low at a rising edge, `mem_addr` takes the value of `ext_addr` sampled at that edge.
- R4: When `strobe_n` and `step_n` are both low, with `clr_n` high, the loaded value is `ext_addr` itself and not `ext_addr` + 1.
- R5: With `clr_n` and `strobe_n` high and `step_n` low at a rising edge, `mem_addr` becomes its previous value plus one.
- R6: With `clr_n`, `strobe_n` and `step_n` all high, `mem_addr` keeps its value, and changes on `ext_addr` have no effect on it.
- R7: Stepping from the all-ones address (0x3FFF at the default width) gives 0x0000.
- R8: `mem_addr` changes only at a rising edge of `clk`, one cycle after the controls that cause the change are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; every action happens on its rising edge |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| clr_n | input | 1 | Counter clear, active low, highest priority |
| strobe_n | input | 1 | Address strobe, active low; loads `ext_addr` |
| step_n | input | 1 | Count enable, active low; adds one |
| ext_addr | input | ADDR_W (14) | Externally supplied start address |
| mem_addr | output | ADDR_W (14) | Registered address sent to the memory array |

## Verification
The bench drives control combinations where two or three controls are active together. A design with the priority order wrong would return ext_addr + 1 on a combined load and count, or would load rather than clear. The bench walks the counter through the all-ones address. A design that saturates at all-ones, or carries into a wider register, would show 0x3FFF or a wrong value there instead of zero. The bench toggles `ext_addr` during hold cycles, which exposes a counter that drifts or that samples the external address when it should not. A long run of random controls, checked against an independent priority model, catches mistakes in the transitions between modes.

// File: rtl/bac_pkg.sv
// Package bac_pkg: the operation types shared by the burst address counter
// modules. The type carries no state. Its ordering is not significant.
package bac_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } bac_op_t;
endpackage

// File: rtl/bac_op_decode.sv
// bac_op_decode: turns the three active-low controls into a single operation.
// The priority is clear, then load, then step, then hold.
// Assumes the inputs are already synchronous to the port clock.
module bac_op_decode
    import bac_pkg::*;
(
    input  logic    clr_n,
    input  logic    strobe_n,
    input  logic    step_n,
    output bac_op_t op
);
    // Priority encoder over the active-low controls.
    always_comb begin
        if (!clr_n)         op = OP_CLEAR;
        else if (!strobe_n) op = OP_LOAD;
        else if (!step_n)   op = OP_STEP;
        else                op = OP_HOLD;
    end
endmodule

// File: rtl/bac_next_addr.sv
// bac_next_addr: computes the next address from the chosen operation.
// The increment is taken modulo 2**ADDR_W, so the all-ones value steps to zero.
// Assumes that op is already resolved by priority.
module bac_next_addr
    import bac_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  bac_op_t           op,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] ext,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] inc;

    // Wrapping incrementer; any carry out of the top bit is dropped.
    always_comb inc = cur + ONE;

    // Selects the next value for the operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ext;
            OP_STEP:  nxt = inc;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bac_addr_reg.sv
// bac_addr_reg: the address register. It clears synchronously while rst_n is
// low and otherwise takes d on every rising edge.
// Assumes that d already holds the hold value when no change is wanted.
module bac_addr_reg #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/burst_addr_counter.sv
// burst_addr_counter: the per-port burst address generator. Clear, load,
// step and hold are chosen each cycle by priority, and the result is
// registered onto mem_addr. There is no chip-enable input, so the counter
// acts on its controls whether or not the port is selected.
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] mem_addr
);
    bac_op_t           op;
    logic [ADDR_W-1:0] nxt;

    bac_op_decode u_dec (
        .clr_n    (clr_n),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .op       (op)
    );

    bac_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
        .op  (op),
        .cur (mem_addr),
        .ext (ext_addr),
        .nxt (nxt)
    );

    bac_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (mem_addr)
    );
endmodule

// File: rtl/bac_checker.sv
// bac_checker: properties of burst_addr_counter, observed at its ports only.
// It is bound to every instance of the top module.
module bac_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              strobe_n,
    input logic              step_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] mem_addr
);
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> mem_addr == '0);

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> mem_addr == '0);

    // R3 and R4: a load takes ext_addr even when step_n is also active.
    p_load_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !strobe_n) |=> mem_addr == $past(ext_addr));

    // R5 and R7: the step is taken modulo the width.
    p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && !step_n) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && step_n) |=> $stable(mem_addr));
endmodule

bind burst_addr_counter bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .ext_addr (ext_addr),
    .mem_addr (mem_addr)
);

// File: tb/burst_addr_counter_bench.sv
// Bench for burst_addr_counter. Inputs are driven on the falling edge and
// mem_addr is sampled on the next falling edge, after one rising edge.
module burst_addr_counter_bench;
    localparam int AW = 14;

    typedef struct packed {
        logic          clr_n;
        logic          strobe_n;
        logic          step_n;
        logic [AW-1:0] ext;
        logic [AW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b1, 14'h0100, 14'h0100, 4'd3}, // R3 load
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h0101, 4'd5}, // R5 step
        '{1'b1, 1'b1, 1'b0, 14'h1111, 14'h0102, 4'd5}, // R5 step
        '{1'b1, 1'b1, 1'b1, 14'h2AAA, 14'h0102, 4'd6}, // R6 hold, ext ignored
        '{1'b1, 1'b0, 1'b0, 14'h1234, 14'h1234, 4'd4}, // R4 load beats step
        '{1'b0, 1'b0, 1'b0, 14'h0555, 14'h0000, 4'd2}, // R2 clear beats all
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h0001, 4'd5}, // R5 step
        '{1'b0, 1'b1, 1'b1, 14'h3333, 14'h0000, 4'd2}, // R2 clear
        '{1'b1, 1'b0, 1'b1, 14'h3FFE, 14'h3FFE, 4'd3}, // R3 load
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h3FFF, 4'd5}, // R5 step
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h0000, 4'd7}, // R7 wrap
        '{1'b1, 1'b1, 1'b1, 14'h3FFF, 14'h0000, 4'd6}  // R6 hold
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] model = '0;

    always #4 clk = ~clk;

    burst_addr_counter #(.ADDR_W(AW)) u_burst_addr_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .ext_addr (ext_addr),
        .mem_addr (mem_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (mem_addr !== exp) begin
            errors++;
            $display("FAIL %s mem_addr=%h expected=%h", req, mem_addr, exp);
        end
    endtask

    // Drives one cycle: apply at the falling edge, then wait one full cycle.
    task automatic cycle(input logic c, input logic s, input logic e,
                         input logic [AW-1:0] a);
        clr_n = c; strobe_n = s; step_n = e; ext_addr = a;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] cur,
        input logic c, input logic s, input logic e, input logic [AW-1:0] a);
        if (!c)      return '0;
        else if (!s) return a;
        else if (!e) return cur + 1'b1;
        else         return cur;
    endfunction

    initial begin
        @(negedge clk);
        // R1: reset while the controls request a load
        cycle(1'b1, 1'b0, 1'b0, 14'h2222);
        check("R1", 14'h0000);
        rst_n = 1'b1;

        // Table walk. R8: each result is sampled one edge after its controls.
        for (int i = 0; i < NV; i++) begin
            cycle(TBL[i].clr_n, TBL[i].strobe_n, TBL[i].step_n, TBL[i].ext);
            check($sformatf("R%0d", TBL[i].req), TBL[i].exp);
        end

        // R1: reset from a nonzero value, with step requested
        cycle(1'b1, 1'b0, 1'b1, 14'h0ABC);
        check("R3", 14'h0ABC);
        rst_n = 1'b0;
        cycle(1'b1, 1'b1, 1'b0, 14'h0000);
        check("R1", 14'h0000);
        rst_n = 1'b1;

        // R7: wrap across several steps from the top
        cycle(1'b1, 1'b0, 1'b1, 14'h3FFD);
        for (int k = 0; k < 4; k++) begin
            cycle(1'b1, 1'b1, 1'b0, 14'h0000);
            check("R7", AW'(14'h3FFE + k));
        end

        // R6: long hold while ext_addr toggles
        cycle(1'b1, 1'b0, 1'b1, 14'h1357);
        for (int k = 0; k < 5; k++) begin
            cycle(1'b1, 1'b1, 1'b1, AW'($urandom));
            check("R6", 14'h1357);
        end

        // Random control sequence against the priority model (R2..R7)
        model = mem_addr;
        for (int k = 0; k < 2000; k++) begin
            logic c, s, e;
            logic [AW-1:0] a;
            c = ($urandom % 8) != 0;
            s = ($urandom % 4) != 0;
            e = ($urandom % 2) != 0;
            a = AW'($urandom);
            model = ref_next(model, c, s, e, a);
            cycle(c, s, e, a);
            check("R2-model", model);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule